// File: doc/BRIEF.md
# Ready-Gated Cross-Domain Configuration Register Bank

This block keeps a small bank of configuration registers in a peripheral clock domain, separate from the bus that programs them. Each bus access that has to reach the far domain, a register update or a fetch of the current values, is carried across by a toggle request and a toggle acknowledge. Each toggle passes through a two-flop synchronizer. A single ready flag on the bus side shows whether the remote bank is free. Software checks the flag before it writes. Writes that arrive while the bank is busy are thrown away.

Reads are served from a bus-side shadow copy. Software can fill the shadow ahead of time by setting the read-request bit in the control word. A register read then completes at once and uses up that copy. A register read with no fresh copy behind it starts its own fetch and asserts `bus_stall` until the fetch is done. `bus_stall` is the back-pressure signal of the read path. While it is high, the master must hold `bus_rd_en` and `bus_addr` steady. The read completes in the first cycle with `bus_rd_en` high and `bus_stall` low, and `bus_rdata` is valid in that cycle. Writes never stall. When the module-enable input is low, reads return the shadow at once.

Each rise of the ready flag can latch an interrupt flag. The interrupt output is that flag masked by a global enable.

Top module: `cdc_cfg_regs`

## Requirements
- R1: A write to a configuration address (below `NUM_REGS`) while `ready_o` is 1 is accepted. `ready_o` reads 0 in the cycle after the write. Once the handshake completes, `ready_o` returns to 1 and the addressed word of `cfg_out` holds the written data.
- R2: A write to a configuration address while `ready_o` is 0 is discarded. No word of `cfg_out` changes because of it.
- R3: An interrupt flag is set by each 0-to-1 change of `ready_o`, but only if `irq_en` was 1 in the cycle of the change. `irq_o` equals the flag ANDed with `glb_irq_en`. Writing a word with bit 1 set to the control address (`NUM_REGS`) clears the flag.
- R4: Writing a word with bit 0 set to the control address while `ready_o` is 1 drops `ready_o` and fetches every remote word into the shadow. After the fetch, `ready_o` is 1 and the fresh status bit is set. Control reads return status as bit 0 ready, bit 1 interrupt flag, bit 2 fresh.
- R5: A configuration read with the module enabled and no fresh shadow asserts `bus_stall`, starts a fetch on its own, and keeps stalling until the fetch is done. It then returns the current remote value. Every completed configuration read clears the fresh bit.
- R6: With `mod_en` low, configuration reads never stall. They return the shadow contents and leave the fresh bit unchanged.
- R7: After reset, `ready_o` is 1, `irq_o` is 0 and every word of `cfg_out` equals `RESET_VAL`.
- R8: A configuration read with the module enabled completes only while `ready_o` is 1. A read issued during a write handshake stalls through that handshake and returns the newly written value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bclk | input | 1 | Bus-side clock |
| rst_bn | input | 1 | Bus-side asynchronous reset, active low |
| pclk | input | 1 | Peripheral-side clock |
| rst_pn | input | 1 | Peripheral-side asynchronous reset, active low |
| bus_wr_en | input | 1 | Write strobe, one cycle per write |
| bus_rd_en | input | 1 | Read request, held while stalled |
| bus_addr | input | ADDR_W | Word address; `NUM_REGS` selects the control/status word |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, valid when `bus_rd_en` is high and `bus_stall` is low |
| bus_stall | output | 1 | Read back-pressure |
| mod_en | input | 1 | Module enable; low makes reads immediate |
| irq_en | input | 1 | Enable for latching the ready-rise interrupt |
| glb_irq_en | input | 1 | Global interrupt mask |
| ready_o | output | 1 | Remote bank free for access |
| irq_o | output | 1 | Interrupt request |
| cfg_out | output | NUM_REGS*DATA_W | Remote register words, peripheral domain, word i at bits i*DATA_W |

## Verification
The bench builds the block with four 16-bit registers and a non-zero reset value of 5A5A. A dropped write therefore leaves a word that can be told apart from both zero and the written data. The peripheral clock runs at a period that is not a multiple of the bus clock period, so the handshake delay varies from one access to the next. Four words are enough to cover a read of a word other than the last one written, a dropped write aimed at a second word, and a read issued during a write handshake.

// File: rtl/cdc_cfg_pkg.sv
package cdc_cfg_pkg;
  typedef enum logic {
    OP_WRITE = 1'b0,
    OP_READ  = 1'b1
  } cfg_op_e;

  // control word bits (write side)
  localparam int CTL_RDREQ  = 0;
  localparam int CTL_IRQCLR = 1;
  // status word bits (read side)
  localparam int STS_READY  = 0;
  localparam int STS_IRQ    = 1;
  localparam int STS_FRESH  = 2;
endpackage

// File: rtl/cdc_bit_sync.sv
module cdc_bit_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '0;
    else        chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/cdc_cfg_bus.sv
module cdc_cfg_bus
  import cdc_cfg_pkg::*;
#(
  parameter int NUM_REGS = 4,
  parameter int DATA_W   = 16,
  parameter int ADDR_W   = 3,
  parameter int IDX_W    = 2
) (
  input  logic                             bclk,
  input  logic                             rst_bn,
  input  logic                             wr_en,
  input  logic                             rd_en,
  input  logic [ADDR_W-1:0]                addr,
  input  logic [DATA_W-1:0]                wdata,
  output logic [DATA_W-1:0]                rdata,
  output logic                             stall,
  input  logic                             mod_en,
  input  logic                             irq_en,
  input  logic                             glb_irq_en,
  output logic                             ready,
  output logic                             irq,
  // handshake toward the peripheral domain
  output logic                             req_tgl,
  output cfg_op_e                          op,
  output logic [IDX_W-1:0]                 pay_idx,
  output logic [DATA_W-1:0]                pay_data,
  input  logic                             ack_s,
  input  logic [NUM_REGS-1:0][DATA_W-1:0]  snap
);
  localparam logic [ADDR_W-1:0] CTRL_ADDR = ADDR_W'(NUM_REGS);

  logic                            ack_prev;
  logic                            ack_edge;
  logic                            fresh;
  logic                            irq_flag;
  logic [NUM_REGS-1:0][DATA_W-1:0] shadow;

  logic cfg_hit, ctrl_hit;
  logic wr_cfg, rdreq_cmd, irq_clr;
  logic launch_wr, launch_rd, rd_done;

  always_comb begin
    cfg_hit   = (addr < CTRL_ADDR);
    ctrl_hit  = (addr == CTRL_ADDR);
    wr_cfg    = wr_en && cfg_hit;
    rdreq_cmd = wr_en && ctrl_hit && wdata[CTL_RDREQ];
    irq_clr   = wr_en && ctrl_hit && wdata[CTL_IRQCLR];
    stall     = rd_en && mod_en && cfg_hit && !(fresh && ready);
    launch_wr = ready && wr_cfg;
    launch_rd = ready && !wr_cfg && (rdreq_cmd || stall);
    rd_done   = rd_en && mod_en && cfg_hit && !stall;
    ack_edge  = ack_s ^ ack_prev;
  end

  // launch and completion of remote operations
  always_ff @(posedge bclk or negedge rst_bn) begin
    if (!rst_bn) begin
      ack_prev <= 1'b0;
      req_tgl  <= 1'b0;
      ready    <= 1'b1;
      op       <= OP_WRITE;
      pay_idx  <= '0;
      pay_data <= '0;
    end else begin
      ack_prev <= ack_s;
      if (launch_wr) begin
        req_tgl  <= ~req_tgl;
        ready    <= 1'b0;
        op       <= OP_WRITE;
        pay_idx  <= addr[IDX_W-1:0];
        pay_data <= wdata;
      end else if (launch_rd) begin
        req_tgl  <= ~req_tgl;
        ready    <= 1'b0;
        op       <= OP_READ;
      end else if (ack_edge) begin
        ready    <= 1'b1;
      end
    end
  end

  // read shadow and its freshness
  always_ff @(posedge bclk or negedge rst_bn) begin
    if (!rst_bn) begin
      fresh  <= 1'b0;
      shadow <= '0;
    end else begin
      if (ack_edge && op == OP_READ) begin
        shadow <= snap;
        fresh  <= 1'b1;
      end else if (launch_wr || rd_done) begin
        fresh  <= 1'b0;
      end
    end
  end

  // edge-triggered interrupt flag, set wins over clear
  always_ff @(posedge bclk or negedge rst_bn) begin
    if (!rst_bn)                 irq_flag <= 1'b0;
    else if (ack_edge && irq_en) irq_flag <= 1'b1;
    else if (irq_clr)            irq_flag <= 1'b0;
  end

  assign irq = irq_flag && glb_irq_en;

  always_comb begin
    rdata = '0;
    if (cfg_hit) begin
      rdata = shadow[addr[IDX_W-1:0]];
    end else if (ctrl_hit) begin
      rdata[STS_READY] = ready;
      rdata[STS_IRQ]   = irq_flag;
      rdata[STS_FRESH] = fresh;
    end
  end
endmodule

// File: rtl/cdc_cfg_remote.sv
module cdc_cfg_remote
  import cdc_cfg_pkg::*;
#(
  parameter int                 NUM_REGS  = 4,
  parameter int                 DATA_W    = 16,
  parameter int                 IDX_W     = 2,
  parameter logic [DATA_W-1:0]  RESET_VAL = '0
) (
  input  logic                             pclk,
  input  logic                             rst_pn,
  input  logic                             req_s,
  input  cfg_op_e                          op,
  input  logic [IDX_W-1:0]                 pay_idx,
  input  logic [DATA_W-1:0]                pay_data,
  output logic                             ack_tgl,
  output logic [NUM_REGS-1:0][DATA_W-1:0]  regs,
  output logic [NUM_REGS-1:0][DATA_W-1:0]  snap
);
  logic req_prev;
  logic req_edge;

  assign req_edge = req_s ^ req_prev;

  always_ff @(posedge pclk or negedge rst_pn) begin
    if (!rst_pn) begin
      req_prev <= 1'b0;
      ack_tgl  <= 1'b0;
    end else begin
      req_prev <= req_s;
      if (req_edge) ack_tgl <= ~ack_tgl;
    end
  end

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_word
    always_ff @(posedge pclk or negedge rst_pn) begin
      if (!rst_pn) begin
        regs[i] <= RESET_VAL;
        snap[i] <= RESET_VAL;
      end else if (req_edge) begin
        if (op == OP_WRITE && pay_idx == IDX_W'(i)) regs[i] <= pay_data;
        if (op == OP_READ)                          snap[i] <= regs[i];
      end
    end
  end
endmodule

// File: rtl/cdc_cfg_regs.sv
module cdc_cfg_regs
  import cdc_cfg_pkg::*;
#(
  parameter int                 NUM_REGS  = 4,
  parameter int                 DATA_W    = 16,
  parameter logic [DATA_W-1:0]  RESET_VAL = '0,
  localparam int                ADDR_W    = $clog2(NUM_REGS + 1),
  localparam int                IDX_W     = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
  input  logic                        bclk,
  input  logic                        rst_bn,
  input  logic                        pclk,
  input  logic                        rst_pn,
  input  logic                        bus_wr_en,
  input  logic                        bus_rd_en,
  input  logic [ADDR_W-1:0]           bus_addr,
  input  logic [DATA_W-1:0]           bus_wdata,
  output logic [DATA_W-1:0]           bus_rdata,
  output logic                        bus_stall,
  input  logic                        mod_en,
  input  logic                        irq_en,
  input  logic                        glb_irq_en,
  output logic                        ready_o,
  output logic                        irq_o,
  output logic [NUM_REGS*DATA_W-1:0]  cfg_out
);
  logic                            req_tgl, req_s;
  logic                            ack_tgl, ack_s;
  cfg_op_e                         op;
  logic [IDX_W-1:0]                pay_idx;
  logic [DATA_W-1:0]               pay_data;
  logic [NUM_REGS-1:0][DATA_W-1:0] regs;
  logic [NUM_REGS-1:0][DATA_W-1:0] snap;

  cdc_cfg_bus #(
    .NUM_REGS (NUM_REGS),
    .DATA_W   (DATA_W),
    .ADDR_W   (ADDR_W),
    .IDX_W    (IDX_W)
  ) bus_i (
    .bclk       (bclk),
    .rst_bn     (rst_bn),
    .wr_en      (bus_wr_en),
    .rd_en      (bus_rd_en),
    .addr       (bus_addr),
    .wdata      (bus_wdata),
    .rdata      (bus_rdata),
    .stall      (bus_stall),
    .mod_en     (mod_en),
    .irq_en     (irq_en),
    .glb_irq_en (glb_irq_en),
    .ready      (ready_o),
    .irq        (irq_o),
    .req_tgl    (req_tgl),
    .op         (op),
    .pay_idx    (pay_idx),
    .pay_data   (pay_data),
    .ack_s      (ack_s),
    .snap       (snap)
  );

  cdc_bit_sync #(.STAGES(2)) req_sync_i (
    .clk   (pclk),
    .rst_n (rst_pn),
    .d     (req_tgl),
    .q     (req_s)
  );

  cdc_bit_sync #(.STAGES(2)) ack_sync_i (
    .clk   (bclk),
    .rst_n (rst_bn),
    .d     (ack_tgl),
    .q     (ack_s)
  );

  cdc_cfg_remote #(
    .NUM_REGS  (NUM_REGS),
    .DATA_W    (DATA_W),
    .IDX_W     (IDX_W),
    .RESET_VAL (RESET_VAL)
  ) remote_i (
    .pclk     (pclk),
    .rst_pn   (rst_pn),
    .req_s    (req_s),
    .op       (op),
    .pay_idx  (pay_idx),
    .pay_data (pay_data),
    .ack_tgl  (ack_tgl),
    .regs     (regs),
    .snap     (snap)
  );

  assign cfg_out = regs;
endmodule

// File: rtl/cdc_cfg_regs_chk.sv
module cdc_cfg_regs_chk #(
  parameter int NUM_REGS = 4,
  parameter int ADDR_W   = 3
) (
  input logic              bclk,
  input logic              rst_bn,
  input logic              bus_wr_en,
  input logic              bus_rd_en,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_stall,
  input logic              mod_en,
  input logic              irq_en,
  input logic              glb_irq_en,
  input logic              ready_o,
  input logic              irq_o
);
  logic cfg_sel;
  assign cfg_sel = (bus_addr < ADDR_W'(NUM_REGS));

  // R1 / R4: the bank only becomes busy as the result of a bus access
  p_busy_from_access_r1: assert property (@(posedge bclk) disable iff (!rst_bn)
    $fell(ready_o) |-> $past(bus_wr_en || bus_rd_en));

  // R3: an enabled ready rise raises the request when not masked
  p_irq_on_rise_r3: assert property (@(posedge bclk) disable iff (!rst_bn)
    ($rose(ready_o) && $past(irq_en) && glb_irq_en) |-> irq_o);

  // R3: global mask
  p_irq_masked_r3: assert property (@(posedge bclk) disable iff (!rst_bn)
    !glb_irq_en |-> !irq_o);

  // R5: stall only appears against a pending read
  p_stall_needs_read_r5: assert property (@(posedge bclk) disable iff (!rst_bn)
    bus_stall |-> (bus_rd_en && cfg_sel));

  // R6: disabled module never stalls
  p_no_stall_disabled_r6: assert property (@(posedge bclk) disable iff (!rst_bn)
    !mod_en |-> !bus_stall);

  // R8: an enabled configuration read only completes while ready
  p_read_when_ready_r8: assert property (@(posedge bclk) disable iff (!rst_bn)
    (bus_rd_en && mod_en && cfg_sel && !bus_stall) |-> ready_o);
endmodule

bind cdc_cfg_regs cdc_cfg_regs_chk #(
  .NUM_REGS (NUM_REGS),
  .ADDR_W   (ADDR_W)
) chk_i (
  .bclk       (bclk),
  .rst_bn     (rst_bn),
  .bus_wr_en  (bus_wr_en),
  .bus_rd_en  (bus_rd_en),
  .bus_addr   (bus_addr),
  .bus_stall  (bus_stall),
  .mod_en     (mod_en),
  .irq_en     (irq_en),
  .glb_irq_en (glb_irq_en),
  .ready_o    (ready_o),
  .irq_o      (irq_o)
);

// File: tb/cdc_cfg_regs_tb_top.sv
module cdc_cfg_regs_tb_top;
  localparam int          CLK_PERIOD = 10;
  localparam int          PCLK_PER   = 14;
  localparam int          NREG       = 4;
  localparam int          DW         = 16;
  localparam int          AW         = $clog2(NREG + 1);
  localparam logic [DW-1:0] RV       = 16'h5A5A;
  localparam logic [AW-1:0] CTRL     = AW'(NREG);

  logic bclk = 1'b0, pclk = 1'b0;
  logic rst_bn = 1'b0, rst_pn = 1'b0;
  logic bus_wr_en = 1'b0, bus_rd_en = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [DW-1:0] bus_wdata = '0;
  logic [DW-1:0] bus_rdata;
  logic bus_stall, ready_o, irq_o;
  logic mod_en = 1'b1, irq_en = 1'b0, glb_irq_en = 1'b1;
  logic [NREG*DW-1:0] cfg_out;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) bclk = ~bclk;
  always #(PCLK_PER/2)   pclk = ~pclk;

  cdc_cfg_regs #(.NUM_REGS(NREG), .DATA_W(DW), .RESET_VAL(RV)) dut_i (
    .bclk(bclk), .rst_bn(rst_bn), .pclk(pclk), .rst_pn(rst_pn),
    .bus_wr_en(bus_wr_en), .bus_rd_en(bus_rd_en), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_stall(bus_stall),
    .mod_en(mod_en), .irq_en(irq_en), .glb_irq_en(glb_irq_en),
    .ready_o(ready_o), .irq_o(irq_o), .cfg_out(cfg_out)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] word(input int i);
    return cfg_out[i*DW +: DW];
  endfunction

  task automatic bus_write(input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge bclk);
    bus_wr_en = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge bclk);
    bus_wr_en = 1'b0;
  endtask

  task automatic bus_read(input logic [AW-1:0] a, output logic [DW-1:0] d, output int stalls);
    stalls = 0;
    @(negedge bclk);
    bus_rd_en = 1'b1; bus_addr = a;
    #1;
    while (bus_stall) begin
      stalls++;
      @(negedge bclk);
      #1;
    end
    d = bus_rdata;
    @(negedge bclk);
    bus_rd_en = 1'b0;
  endtask

  task automatic wait_ready();
    while (!ready_o) @(negedge bclk);
    @(negedge bclk);
  endtask

  task automatic t_reset();
    chk("R7 ready after reset", ready_o, 1);
    chk("R7 irq after reset", irq_o, 0);
    chk("R7 word0 reset value", word(0), RV);
    chk("R7 word3 reset value", word(3), RV);
  endtask

  task automatic t_write();
    bus_write(2, 16'h1234);
    chk("R1 ready low after write", ready_o, 0);
    wait_ready();
    chk("R1 ready back", ready_o, 1);
    chk("R1 word2 updated", word(2), 16'h1234);
  endtask

  task automatic t_drop();
    bus_write(0, 16'hAAAA);
    bus_write(1, 16'hBBBB);
    wait_ready();
    chk("R2 accepted word0", word(0), 16'hAAAA);
    chk("R2 dropped word1", word(1), RV);
  endtask

  task automatic t_readreq();
    logic [DW-1:0] d; int s;
    bus_write(CTRL, 16'h0001);
    chk("R4 ready low during fetch", ready_o, 0);
    wait_ready();
    bus_read(CTRL, d, s);
    chk("R4 status ready+fresh", d & 16'h0005, 16'h0005);
    bus_read(2, d, s);
    chk("R4 prefetched read no stall", s, 0);
    chk("R4 prefetched data", d, 16'h1234);
    bus_read(CTRL, d, s);
    chk("R5 fresh consumed", d[2], 0);
  endtask

  task automatic t_autoread();
    logic [DW-1:0] d; int s;
    bus_read(0, d, s);
    chk("R5 read stalls", s > 0, 1);
    chk("R5 auto-fetched data", d, 16'hAAAA);
    chk("R5 ready after read", ready_o, 1);
  endtask

  task automatic t_read_during_write();
    logic [DW-1:0] d; int s;
    bus_write(1, 16'h0C0C);
    chk("R8 write in flight", ready_o, 0);
    bus_read(1, d, s);
    chk("R8 read stalled through handshake", s > 2, 1);
    chk("R8 new value returned", d, 16'h0C0C);
  endtask

  task automatic t_disabled();
    logic [DW-1:0] d; int s;
    bus_write(CTRL, 16'h0001);
    wait_ready();
    mod_en = 1'b0;
    bus_read(3, d, s);
    chk("R6 no stall disabled", s, 0);
    chk("R6 shadow data", d, RV);
    bus_read(CTRL, d, s);
    chk("R6 fresh kept", d[2], 1);
    mod_en = 1'b1;
  endtask

  task automatic t_irq();
    logic [DW-1:0] d; int s;
    irq_en = 1'b1; glb_irq_en = 1'b1;
    bus_write(3, 16'h0007);
    wait_ready();
    chk("R3 irq after rise", irq_o, 1);
    bus_read(CTRL, d, s);
    chk("R3 status irq bit", d[1], 1);
    bus_write(CTRL, 16'h0002);
    chk("R3 irq cleared", irq_o, 0);
    glb_irq_en = 1'b0;
    bus_write(3, 16'h0008);
    wait_ready();
    chk("R3 masked by global", irq_o, 0);
    glb_irq_en = 1'b1;
    #1;
    chk("R3 unmasked flag shows", irq_o, 1);
    bus_write(CTRL, 16'h0002);
    irq_en = 1'b0;
    bus_write(3, 16'h0009);
    wait_ready();
    chk("R3 not latched when disabled", irq_o, 0);
    chk("R1 word3 final", word(3), 16'h0009);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge bclk);
    rst_bn = 1'b1; rst_pn = 1'b1;
    repeat (2) @(negedge bclk);
    t_reset();
    t_write();
    t_drop();
    t_readreq();
    t_autoread();
    t_read_during_write();
    t_disabled();
    t_irq();
    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule